// File: doc/BRIEF.md
# Host-Settable Device Timestamp

This block holds a device timestamp that the host loads and reads back with mailbox-style commands. A load command carries a 64-bit host time. The block stores that value and takes a snapshot of a free-running nanosecond tick count in the same cycle. A read command returns the stored host time plus the ticks that have passed since the load. Until the first load, every read returns zero.

Each command gets one response, one cycle after its strobe. The response has a valid pulse, a byte count and the value split into byte lanes. Lane 0 holds the least significant byte. A load must declare a length of exactly eight bytes. If it declares any other length, the block ignores the load and raises an error flag. The tick source is expected to be in the block's own clock domain already.

The controller has two states. `TS_UNSET` is entered on reset, and in it reads return zero. The transition to `TS_ARMED` happens on the first accepted load. `TS_ARMED` only leaves through reset, and further loads overwrite the stored pair. The response register is kept in a separate output process.

Top module: `tsu_top`

## Requirements
- R1: A synchronous reset clears the response outputs (`rsp_valid`, `rsp_len`, `rsp_len_err` and all bytes are 0) and returns the controller to `TS_UNSET`.
- R2: A read issued before any accepted load responds with the value 0.
- R3: A load with `set_len` equal to 8 stores `set_data` and the current `tick_ns`. Its response has `rsp_len` = 0 and all-zero bytes when no read comes with it.
- R4: In `TS_ARMED`, a read returns stored_host + (`tick_ns` in the read cycle − stored_tick).
- R5: The elapsed-tick subtraction wraps modulo 2^64, so a tick counter rollover between the load and the read still gives the true elapsed count.
- R6: When a load and a read strobe in the same cycle, the load is applied first and the read returns exactly that cycle's `set_data`.
- R7: A load whose `set_len` is not 8 sets `rsp_len_err` in its response and leaves the stored host value, the stored tick and the state unchanged.
- R8: A read response has `rsp_len` = 8, and `rsp_bytes[k]` carries bits 8k+7..8k of the value (little-endian lane order).
- R9: `rsp_valid` is high in exactly the cycles that follow a cycle with `set_stb` or `get_stb` asserted.
- R10: After a reset, a read returns 0 again, even if a load was accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ns | input | 64 | Free-running nanosecond tick count |
| set_stb | input | 1 | Load command strobe |
| set_len | input | 16 | Declared input length of the load command, in bytes |
| set_data | input | 64 | Host time carried by the load command |
| get_stb | input | 1 | Read command strobe |
| rsp_valid | output | 1 | Response present (one cycle after a strobe) |
| rsp_len | output | 16 | Response length in bytes (8 for a read, 0 otherwise) |
| rsp_len_err | output | 1 | Load rejected for a wrong declared length |
| rsp_bytes | output | 8x8 | Response value, lane 0 = least significant byte |

## Verification
The assertions check the command-to-response rules on every cycle:
- the single-cycle response timing;
- the zero-length, zero-data reply to a lone load;
- the length flag on a rejected load;
- the fixed read length;
- the read-after-load ordering in a shared cycle;
- the quiet outputs after reset.

The arithmetic needs stored state that only the bench's reference model follows. Those scenarios are:
- elapsed time across a tick rollover;
- a read that still sees the older stored pair after a rejected load;
- zero returned before the first load and again after a later reset.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    typedef enum logic [0:0] {
        TS_UNSET = 1'b0,
        TS_ARMED = 1'b1
    } tsu_state_e;
endpackage

// File: rtl/tsu_elapsed.sv
// Host time plus elapsed ticks; zero while not armed. Subtraction wraps (R5).
module tsu_elapsed #(
    parameter int unsigned W = 64
) (
    input  logic         armed,
    input  logic [W-1:0] host_val,
    input  logic [W-1:0] base_tick,
    input  logic [W-1:0] now_tick,
    output logic [W-1:0] value
);
    logic [W-1:0] delta;

    always_comb begin
        delta = now_tick - base_tick;
        value = armed ? (host_val + delta) : '0;
    end
endmodule

// File: rtl/tsu_le_pack.sv
// Splits a word into byte lanes, lane 0 least significant (R8).
module tsu_le_pack #(
    parameter int unsigned BYTES = 8
) (
    input  logic [8*BYTES-1:0]    word,
    output logic [BYTES-1:0][7:0] lanes
);
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign lanes[k] = word[8*k +: 8];
    end
endmodule

// File: rtl/tsu_top.sv
module tsu_top
    import tsu_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned LENW  = 16,
    localparam int unsigned BYTES = W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          tick_ns,
    input  logic                  set_stb,
    input  logic [LENW-1:0]       set_len,
    input  logic [W-1:0]          set_data,
    input  logic                  get_stb,
    output logic                  rsp_valid,
    output logic [LENW-1:0]       rsp_len,
    output logic                  rsp_len_err,
    output logic [BYTES-1:0][7:0] rsp_bytes
);
    localparam logic [LENW-1:0] LOAD_LEN = LENW'(BYTES);

    tsu_state_e   state_q, state_d;
    logic [W-1:0] host_q, host_d;
    logic [W-1:0] base_q, base_d;
    logic [W-1:0] word_q;
    logic [W-1:0] read_val;
    logic         load_ok;
    logic         armed_now;

    assign load_ok = set_stb && (set_len == LOAD_LEN);

    // Next-state and stored-pair logic
    always_comb begin
        state_d = state_q;
        host_d  = host_q;
        base_d  = base_q;
        unique case (state_q)
            TS_UNSET: if (load_ok) state_d = TS_ARMED;
            TS_ARMED: state_d = TS_ARMED;
        endcase
        if (load_ok) begin
            host_d = set_data;
            base_d = tick_ns;
        end
        armed_now = (state_d == TS_ARMED);
    end

    // Read path sees the pair after any same-cycle load (R6)
    tsu_elapsed #(.W(W)) u_elapsed (
        .armed    (armed_now),
        .host_val (host_d),
        .base_tick(base_d),
        .now_tick (tick_ns),
        .value    (read_val)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_UNSET;
            host_q  <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            host_q  <= host_d;
            base_q  <= base_d;
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_len     <= '0;
            rsp_len_err <= 1'b0;
            word_q      <= '0;
        end else begin
            rsp_valid   <= set_stb || get_stb;
            rsp_len_err <= set_stb && !load_ok;
            rsp_len     <= get_stb ? LOAD_LEN : '0;
            word_q      <= get_stb ? read_val : '0;
        end
    end

    tsu_le_pack #(.BYTES(BYTES)) u_pack (
        .word (word_q),
        .lanes(rsp_bytes)
    );
endmodule

// File: rtl/tsu_top_chk.sv
module tsu_top_chk #(
    parameter int unsigned W    = 64,
    parameter int unsigned LENW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            set_stb,
    input logic [LENW-1:0] set_len,
    input logic [W-1:0]    set_data,
    input logic            get_stb,
    input logic            rsp_valid,
    input logic [LENW-1:0] rsp_len,
    input logic            rsp_len_err,
    input logic [W-1:0]    rsp_word
);
    localparam logic [LENW-1:0] LOAD_LEN = LENW'(W / 8);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !rsp_len_err && rsp_len == '0));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (set_stb || get_stb) |=> rsp_valid);

    assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !(set_stb || get_stb) |=> !rsp_valid);

    assert_load_reply_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (set_stb && !get_stb) |=> (rsp_len == '0 && rsp_word == '0));

    assert_badlen_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (set_stb && set_len != LOAD_LEN) |=> rsp_len_err);

    assert_read_len_R8: assert property (@(posedge clk) disable iff (rst)
        get_stb |=> rsp_len == LOAD_LEN);

    assert_load_then_read_R6: assert property (@(posedge clk) disable iff (rst)
        (set_stb && get_stb && set_len == LOAD_LEN) |=> rsp_word == $past(set_data));
endmodule

bind tsu_top tsu_top_chk #(.W(W), .LENW(LENW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .set_stb    (set_stb),
    .set_len    (set_len),
    .set_data   (set_data),
    .get_stb    (get_stb),
    .rsp_valid  (rsp_valid),
    .rsp_len    (rsp_len),
    .rsp_len_err(rsp_len_err),
    .rsp_word   (rsp_bytes)
);

// File: tb/tsu_top_test.sv
`timescale 1ns/1ps
module tsu_top_test;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [63:0]     tick_ns = '0;
    logic            set_stb = 1'b0;
    logic [15:0]     set_len = '0;
    logic [63:0]     set_data = '0;
    logic            get_stb = 1'b0;
    logic            rsp_valid;
    logic [15:0]     rsp_len;
    logic            rsp_len_err;
    logic [7:0][7:0] rsp_bytes;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit          m_armed = 0;
    logic [63:0] m_host = '0;
    logic [63:0] m_base = '0;

    always #2 clk = ~clk;

    tsu_top uut (
        .clk(clk), .rst(rst), .tick_ns(tick_ns), .set_stb(set_stb),
        .set_len(set_len), .set_data(set_data), .get_stb(get_stb),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_len_err(rsp_len_err),
        .rsp_bytes(rsp_bytes)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // One clock: drive inputs, predict, then compare every output lane.
    task automatic step(input bit s, input logic [15:0] len, input logic [63:0] d,
                        input bit g, input logic [63:0] t, input string req);
        bit          e_valid, e_err;
        logic [15:0] e_len;
        logic [63:0] e_val;
        logic [63:0] act;
        set_stb = s; set_len = len; set_data = d; get_stb = g; tick_ns = t;
        e_valid = s || g;
        e_err   = s && (len != 16'd8);
        if (s && len == 16'd8) begin
            m_armed = 1; m_host = d; m_base = t;
        end
        e_len = g ? 16'd8 : 16'd0;
        e_val = (g && m_armed) ? m_host + (t - m_base) : 64'd0;
        @(posedge clk); #1;
        set_stb = 0; get_stb = 0;
        act = '0;
        for (int k = 0; k < 8; k++) act = act | (64'(rsp_bytes[k]) << (8 * k));
        tests++;
        if (rsp_valid !== e_valid || rsp_len_err !== e_err || rsp_len !== e_len
            || act !== e_val) begin
            fails++;
            $display("FAIL %s: actual v=%0b err=%0b len=%0d val=%h, expected v=%0b err=%0b len=%0d val=%h",
                     req, rsp_valid, rsp_len_err, rsp_len, act, e_valid, e_err, e_len, e_val);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        m_armed = 0; m_host = '0; m_base = '0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        tests++;
        if (rsp_valid !== 0 || rsp_len !== 0 || rsp_len_err !== 0 || rsp_bytes !== '0) begin
            fails++;
            $display("FAIL R1: actual v=%0b len=%0d bytes=%h, expected all zero",
                     rsp_valid, rsp_len, rsp_bytes);
        end
    endtask

    initial begin
        do_reset();                                              // R1
        step(0, 0, 0, 0, 64'd100, "R9 idle");
        step(0, 0, 0, 1, 64'd105, "R2 read before load");
        step(1, 16'd8, 64'h0000_0100_0000_0000, 0, 64'd110, "R3 load");
        step(0, 0, 0, 0, 64'd115, "R9 idle");
        step(0, 0, 0, 1, 64'd140, "R4 read elapsed");
        step(0, 0, 0, 1, 64'd1140, "R4 read later");
        step(1, 16'd4, 64'hDEAD_BEEF, 0, 64'd1200, "R7 bad length");
        step(0, 0, 0, 1, 64'd1300, "R7 pair unchanged");
        step(1, 16'd9, 64'h1, 1, 64'd1400, "R7 bad length with read");
        step(1, 16'd8, 64'h0102_0304_0506_0708, 1, 64'd1500, "R6 same cycle");
        step(0, 0, 0, 1, 64'd1507, "R8 lane order");
        step(1, 16'd8, 64'hAABB_CCDD_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFD, "R5 load near wrap");
        step(0, 0, 0, 1, 64'd10, "R5 read after wrap");
        step(1, 16'd0, 0, 0, 64'd20, "R7 zero length");
        step(0, 0, 0, 1, 64'd30, "R5 pair kept");
        do_reset();                                              // R1
        step(0, 0, 0, 1, 64'd40, "R10 read after reset");
        step(1, 16'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd50, "R3 load max");
        step(0, 0, 0, 1, 64'd52, "R5 host wraps");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule